// File: doc/BRIEF.md
# Sequential Address and Interrupt Allocator

This block assigns address windows and interrupt numbers to devices one at a time, in the order they register. It holds two running pointers: the next free base address and the next free interrupt number. An init operation loads both pointers from its inputs. Each registration request carries a requested base, a window size, a requested interrupt and an interrupt count. A request that asks for base 0 is given the free base, and the base pointer then moves past the window. A request that asks for interrupt 0 with a non-zero count is given the free interrupt, and the interrupt pointer then moves past the block of interrupts. Any other request value is returned unchanged.

After an interrupt allocation the pointer skips a set of three reserved interrupt numbers, one step per clock, and the block reports busy while it does so. When the pointer ends at or beyond the interrupt limit, a sticky overflow flag is set. From then on every request is answered with a reject until the next init. Each accepted registration also receives its position in the registration order, so the first device after init is the head of the list.

Top module: `res_alloc`

## Requirements
- R1: After reset, rsp_valid, busy and irq_overflow are 0 and req_ready is 1.
- R2: A request with req_base equal to 0 receives the current free base as rsp_base, and the free base then grows by req_size.
- R3: A request with a non-zero req_base receives req_base unchanged as rsp_base, and the free base does not move.
- R4: A request with req_irq equal to 0 and req_irq_cnt greater than 0 receives the current free interrupt as rsp_irq, and the free interrupt then grows by req_irq_cnt.
- R5: A request with a non-zero req_irq, or with req_irq_cnt equal to 0, receives req_irq unchanged as rsp_irq, and the free interrupt does not move.
- R6: When the advanced interrupt pointer equals a reserved number (RSV_A, RSV_B or RSV_C), it is stepped up by one per clock until it does not. busy is 1 for exactly one cycle per step, and req_ready is 0 while busy is 1.
- R7: When the interrupt pointer, once all skips are done, is at or above IRQ_MAX, irq_overflow becomes 1. It stays 1 until the next init.
- R8: While irq_overflow is 1, an accepted request is answered with rsp_reject=1, rsp_base=0 and rsp_irq=0. rsp_index holds the unchanged registration count.
- R9: rsp_index is 0 for the first successful registration after init and grows by one with each later successful registration.
- R10: init_valid loads the free base from init_base and the free interrupt from init_irq. It clears irq_overflow and the registration count and ends any skip in progress. While init_valid is 1, req_ready is 0, so init takes priority over a request in the same cycle.
- R11: A request is accepted on a clock edge where req_valid and req_ready are both 1. The clock edge that follows the acceptance edge makes rsp_valid 1 for one cycle. rsp_valid is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_valid | input | 1 | Load pointers, clear overflow and count |
| init_base | input | ADDR_W | Starting free base |
| init_irq | input | IRQ_W | Starting free interrupt |
| req_valid | input | 1 | Registration request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_base | input | ADDR_W | Requested base, 0 asks for allocation |
| req_size | input | ADDR_W | Window size |
| req_irq | input | IRQ_W | Requested interrupt, 0 asks for allocation |
| req_irq_cnt | input | CNT_W | Number of interrupts |
| rsp_valid | output | 1 | Response pulse |
| rsp_reject | output | 1 | Request refused due to overflow |
| rsp_base | output | ADDR_W | Assigned base |
| rsp_irq | output | IRQ_W | Assigned interrupt |
| rsp_index | output | IDX_W | Position in registration order |
| busy | output | 1 | Reserved-number skip in progress |
| irq_overflow | output | 1 | Sticky interrupt limit error |

## Verification
Init and a registration request can both arrive in the same cycle. The bench drives both together while the block is in the overflow state. It checks that req_ready is low in that cycle and that the request is taken in the next cycle. The response to that request must use the newly loaded pointers, have index 0 and no reject, and irq_overflow must already be cleared.

// File: rtl/alloc_pkg.sv
package alloc_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SKIP = 1'b1
    } alloc_st_e;

endpackage

// File: rtl/alloc_rsv_match.sv
module alloc_rsv_match #(
    parameter int              VAL_W = 7,
    parameter int              NUM   = 3,
    parameter logic [NUM*VAL_W-1:0] LIST = '0
) (
    input  logic [VAL_W-1:0] value,
    output logic             hit
);
    logic [NUM-1:0] each_hit;

    for (genvar g = 0; g < NUM; g++) begin : g_cmp
        assign each_hit[g] = (value == LIST[g*VAL_W +: VAL_W]);
    end

    assign hit = |each_hit;
endmodule

// File: rtl/alloc_base_unit.sv
module alloc_base_unit #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] free_base,
    input  logic [ADDR_W-1:0] want_base,
    input  logic [ADDR_W-1:0] win_size,
    output logic [ADDR_W-1:0] give_base,
    output logic [ADDR_W-1:0] next_base
);
    logic take;

    always_comb begin
        take      = (want_base == '0);
        give_base = take ? free_base : want_base;
        next_base = take ? (free_base + win_size) : free_base;
    end
endmodule

// File: rtl/alloc_irq_unit.sv
module alloc_irq_unit #(
    parameter int IRQ_W = 6,
    parameter int CNT_W = 4,
    localparam int FW   = IRQ_W + 1
) (
    input  logic [FW-1:0]    free_irq,
    input  logic [IRQ_W-1:0] want_irq,
    input  logic [CNT_W-1:0] want_cnt,
    output logic             take,
    output logic [IRQ_W-1:0] give_irq,
    output logic [FW-1:0]    tent_irq
);
    always_comb begin
        take     = (want_irq == '0) && (want_cnt != '0);
        give_irq = take ? free_irq[IRQ_W-1:0] : want_irq;
        tent_irq = take ? (free_irq + FW'(want_cnt)) : free_irq;
    end
endmodule

// File: rtl/res_alloc.sv
module res_alloc
    import alloc_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int IRQ_W   = 6,
    parameter int CNT_W   = 4,
    parameter int IDX_W   = 8,
    parameter int RSV_A   = 5,
    parameter int RSV_B   = 6,
    parameter int RSV_C   = 9,
    parameter int IRQ_MAX = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_valid,
    input  logic [ADDR_W-1:0] init_base,
    input  logic [IRQ_W-1:0]  init_irq,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [ADDR_W-1:0] req_size,
    input  logic [IRQ_W-1:0]  req_irq,
    input  logic [CNT_W-1:0]  req_irq_cnt,
    output logic              rsp_valid,
    output logic              rsp_reject,
    output logic [ADDR_W-1:0] rsp_base,
    output logic [IRQ_W-1:0]  rsp_irq,
    output logic [IDX_W-1:0]  rsp_index,
    output logic              busy,
    output logic              irq_overflow
);
    localparam int FW = IRQ_W + 1;
    localparam int NUM_RSV = 3;
    localparam logic [FW-1:0] MAX_F = FW'(IRQ_MAX);
    localparam logic [NUM_RSV*FW-1:0] RSV_LIST = {FW'(RSV_C), FW'(RSV_B), FW'(RSV_A)};

    typedef struct packed {
        alloc_st_e          st;
        logic [ADDR_W-1:0]  free_base;
        logic [FW-1:0]      free_irq;
        logic               ovf;
        logic [IDX_W-1:0]   idx;
        logic               rv;
        logic               rrej;
        logic [ADDR_W-1:0]  rbase;
        logic [IRQ_W-1:0]   rirq;
        logic [IDX_W-1:0]   ridx;
    } alloc_s_t;

    alloc_s_t d, q;

    logic              accept;
    logic [ADDR_W-1:0] give_base, next_base;
    logic              irq_take;
    logic [IRQ_W-1:0]  give_irq;
    logic [FW-1:0]     tent_irq, step_irq;
    logic              tent_rsv, step_rsv;

    alloc_base_unit #(.ADDR_W(ADDR_W)) u_base (
        .free_base (q.free_base),
        .want_base (req_base),
        .win_size  (req_size),
        .give_base (give_base),
        .next_base (next_base)
    );

    alloc_irq_unit #(.IRQ_W(IRQ_W), .CNT_W(CNT_W)) u_irq (
        .free_irq (q.free_irq),
        .want_irq (req_irq),
        .want_cnt (req_irq_cnt),
        .take     (irq_take),
        .give_irq (give_irq),
        .tent_irq (tent_irq)
    );

    assign step_irq = q.free_irq + FW'(1);

    alloc_rsv_match #(.VAL_W(FW), .NUM(NUM_RSV), .LIST(RSV_LIST)) u_rsv_tent (
        .value (tent_irq),
        .hit   (tent_rsv)
    );

    alloc_rsv_match #(.VAL_W(FW), .NUM(NUM_RSV), .LIST(RSV_LIST)) u_rsv_step (
        .value (step_irq),
        .hit   (step_rsv)
    );

    assign req_ready = (q.st == ST_IDLE) && !init_valid;
    assign accept    = req_valid && req_ready;

    always_comb begin
        d    = q;
        d.rv = 1'b0;
        if (init_valid) begin
            d.st        = ST_IDLE;
            d.free_base = init_base;
            d.free_irq  = {1'b0, init_irq};
            d.ovf       = 1'b0;
            d.idx       = '0;
        end else if (q.st == ST_SKIP) begin
            d.free_irq = step_irq;
            if (!step_rsv) begin
                d.st  = ST_IDLE;
                d.ovf = (step_irq >= MAX_F);
            end
        end else if (accept) begin
            d.rv = 1'b1;
            if (q.ovf) begin
                d.rrej  = 1'b1;
                d.rbase = '0;
                d.rirq  = '0;
                d.ridx  = q.idx;
            end else begin
                d.rrej      = 1'b0;
                d.rbase     = give_base;
                d.rirq      = give_irq;
                d.ridx      = q.idx;
                d.idx       = q.idx + IDX_W'(1);
                d.free_base = next_base;
                if (irq_take) begin
                    d.free_irq = tent_irq;
                    if (tent_rsv) begin
                        d.st = ST_SKIP;
                    end else begin
                        d.ovf = (tent_irq >= MAX_F);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, free_base: '0, free_irq: '0, ovf: 1'b0, idx: '0,
                   rv: 1'b0, rrej: 1'b0, rbase: '0, rirq: '0, ridx: '0};
        end else begin
            q <= d;
        end
    end

    assign rsp_valid    = q.rv;
    assign rsp_reject   = q.rrej;
    assign rsp_base     = q.rbase;
    assign rsp_irq      = q.rirq;
    assign rsp_index    = q.ridx;
    assign busy         = (q.st == ST_SKIP);
    assign irq_overflow = q.ovf;

    assert_busy_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);

    assert_skip_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !init_valid) |=> (q.free_irq == $past(q.free_irq) + FW'(1)));

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_overflow && !init_valid) |=> irq_overflow);

    assert_reject_when_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && irq_overflow) |=> (rsp_valid && rsp_reject));

    assert_init_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        init_valid |-> !req_ready);

    assert_init_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        init_valid |=> (!irq_overflow && !busy));

    assert_rsp_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_valid);

    assert_no_stray_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !rsp_valid);
endmodule

// File: tb/tb_res_alloc.sv
module tb_res_alloc;
    localparam int CLK_PERIOD = 10;
    localparam int RA = 5, RB = 6, RC = 9, IMAX = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_valid = 1'b0;
    logic [31:0] init_base = '0;
    logic [5:0]  init_irq = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_base = '0;
    logic [31:0] req_size = '0;
    logic [5:0]  req_irq = '0;
    logic [3:0]  req_irq_cnt = '0;
    logic        rsp_valid, rsp_reject, busy, irq_overflow;
    logic [31:0] rsp_base;
    logic [5:0]  rsp_irq;
    logic [7:0]  rsp_index;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    typedef struct {
        logic        rej;
        logic [31:0] base;
        logic [5:0]  irq;
        logic [7:0]  idx;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    logic [31:0] m_base;
    int          m_irq;
    logic        m_ovf;
    int          m_idx;

    res_alloc dut (
        .clk(clk), .rst_n(rst_n), .init_valid(init_valid), .init_base(init_base),
        .init_irq(init_irq), .req_valid(req_valid), .req_ready(req_ready),
        .req_base(req_base), .req_size(req_size), .req_irq(req_irq),
        .req_irq_cnt(req_irq_cnt), .rsp_valid(rsp_valid), .rsp_reject(rsp_reject),
        .rsp_base(rsp_base), .rsp_irq(rsp_irq), .rsp_index(rsp_index),
        .busy(busy), .irq_overflow(irq_overflow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    function automatic bit is_rsv(input int v);
        return (v == RA) || (v == RB) || (v == RC);
    endfunction

    // model a request and queue its expected response; returns skip count
    task automatic model_req(input logic [31:0] b, input logic [31:0] s, input int ir,
                             input int cnt, input string tag, output int skips);
        exp_t e;
        skips = 0;
        e.tag = tag;
        if (m_ovf) begin
            e.rej = 1'b1; e.base = '0; e.irq = '0; e.idx = 8'(m_idx);
        end else begin
            e.rej = 1'b0;
            e.idx = 8'(m_idx);
            m_idx++;
            if (b == 0) begin e.base = m_base; m_base = m_base + s; end
            else e.base = b;
            if (ir == 0 && cnt > 0) begin
                e.irq = 6'(m_irq);
                m_irq = m_irq + cnt;
                while (is_rsv(m_irq)) begin m_irq++; skips++; end
                m_ovf = (m_irq >= IMAX);
            end else begin
                e.irq = 6'(ir);
            end
        end
        exp_q.push_back(e);
    endtask

    task automatic do_init(input logic [31:0] b, input int ir);
        @(negedge clk);
        init_valid = 1'b1; init_base = b; init_irq = 6'(ir);
        @(negedge clk);
        init_valid = 1'b0;
        m_base = b; m_irq = ir; m_ovf = 1'b0; m_idx = 0;
    endtask

    task automatic send(input logic [31:0] b, input logic [31:0] s, input int ir,
                        input int cnt, input string tag, input int exp_skips);
        int sk;
        int nb;
        @(negedge clk);
        req_valid = 1'b1; req_base = b; req_size = s; req_irq = 6'(ir); req_irq_cnt = 4'(cnt);
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        model_req(b, s, ir, cnt, tag, sk);
        @(negedge clk);
        req_valid = 1'b0;
        nb = 0;
        while (busy) begin
            nb++;
            chk("R6 ready low while busy", 32'(req_ready), 32'd0);
            @(negedge clk);
        end
        chk("R6 skip cycles model", sk, exp_skips);
        chk("R6 busy cycles", nb, sk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R11 unexpected response actual=1 expected=0");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk({e.tag, " reject"}, 32'(rsp_reject), 32'(e.rej));
                chk({e.tag, " base"},   rsp_base, e.base);
                chk({e.tag, " irq"},    32'(rsp_irq), 32'(e.irq));
                chk({e.tag, " index R9"}, 32'(rsp_index), 32'(e.idx));
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                total++; bad++;
                $display("FAIL watchdog actual=%0d expected<100000", cycles);
                summary();
            end
        end
    end

    initial begin
        int sk;
        m_base = '0; m_irq = 0; m_ovf = 1'b0; m_idx = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 overflow", 32'(irq_overflow), 32'd0);
        chk("R1 ready", 32'(req_ready), 32'd1);

        do_init(32'h4000, 1);
        send(32'h0,    32'h100, 0, 1, "R2 R4 first", 0);
        send(32'h8000, 32'h50,  0, 0, "R3 R5 passthrough", 0);
        send(32'h0,    32'h20,  7, 2, "R2 R5 fixed irq", 0);
        send(32'h0,    32'h10,  0, 2, "R2 R4 second", 0);
        send(32'h7000, 32'h10,  0, 1, "R6 double skip", 2);
        send(32'h0,    32'h8,   0, 2, "R6 single skip", 1);
        send(32'h0,    32'h0,   0, 15, "R4 wide block", 0);
        chk("R7 no overflow yet", 32'(irq_overflow), 32'd0);
        send(32'h0,    32'h0,   0, 7, "R7 reaching limit", 0);
        chk("R7 overflow set", 32'(irq_overflow), 32'd1);
        send(32'h0,    32'h40,  0, 1, "R8 reject one", 0);
        send(32'h1234, 32'h40,  3, 0, "R8 reject two", 0);
        chk("R7 overflow sticky", 32'(irq_overflow), 32'd1);

        // init and request in the same cycle
        @(negedge clk);
        init_valid = 1'b1; init_base = 32'h9000; init_irq = 6'd30;
        req_valid = 1'b1; req_base = 32'h0; req_size = 32'h4; req_irq = 6'd0; req_irq_cnt = 4'd1;
        #1;
        chk("R10 ready low during init", 32'(req_ready), 32'd0);
        @(negedge clk);
        init_valid = 1'b0;
        m_base = 32'h9000; m_irq = 30; m_ovf = 1'b0; m_idx = 0;
        #1;
        chk("R10 ready after init", 32'(req_ready), 32'd1);
        model_req(32'h0, 32'h4, 0, 1, "R10 collided request", sk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 overflow cleared", 32'(irq_overflow), 32'd0);

        send(32'h0, 32'h4, 0, 1, "R7 R9 after reinit", 0);
        chk("R7 overflow again", 32'(irq_overflow), 32'd1);

        repeat (3) @(negedge clk);
        chk("R11 all responses seen", exp_q.size(), 32'd0);
        summary();
    end
endmodule